// File: doc/BRIEF.md
# Edge-Qualified Conversion Start Arming Unit

This unit decides the moment at which one output channel begins converting. The host chooses a start source and an edge sense, then issues an arm command. With the software source the start happens at once. With either external source (the output of an analog level comparator, or a digital trigger pin) the unit waits for the first qualifying transition that follows the arm command. It issues exactly one single-cycle start pulse and then latches in the triggered state.

The two trigger lines are asynchronous to the unit clock, so each one passes through a two-flop synchroniser. The edge detector compares the synchronised level with its value one cycle earlier. Because that history tracks the selected line at all times, a level that is already present when the arm arrives does not count as an edge. Once the unit has fired, further trigger activity and further arm commands are ignored until the host issues a re-init, which returns the unit to idle.

A channel in a multi-card chain that waits on a master's clock is served by the same behaviour. It stays armed, with no start, until the selected line moves.

Top module: `trig_arm`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, start_pulse, armed and triggered are all 0.
- R2: Source select 2'b00 is the software source. An arm sampled in idle with this source gives start_pulse=1 and triggered=1 in the next cycle, without any trigger input.
- R3: Source select 2'b01 picks the analog comparator line and 2'b1x picks the digital pin. An arm sampled in idle with an external source sets armed=1 in the next cycle and gives no start pulse until a qualifying edge is seen.
- R4: A change on a trigger input that is set up before clock edge k appears in the synchronised level after edge k+1. If that change qualifies while the unit is armed, start_pulse is high after edge k+2.
- R5: Edge sense 2'b00 fires on low-to-high transitions, 2'b01 on high-to-low transitions, and 2'b1x on a transition in either direction.
- R6: Transitions of the selected synchronised level that happen while the unit is idle, including in the cycle the arm is sampled, are discarded. A level already present at arm time never fires.
- R7: start_pulse lasts exactly one clock cycle. The move into the triggered state clears armed and sets triggered, and triggered stays set.
- R8: While triggered, trigger transitions and arm commands produce no further start pulse and do not change armed or triggered.
- R9: reinit returns the unit to idle in the next cycle (armed=0, triggered=0, start_pulse=0) and takes priority over an arm sampled in the same cycle.
- R10: An arm command sampled while the unit is already armed has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Start source: 00 software, 01 analog comparator, 1x digital pin |
| edge_sel | input | 2 | Edge sense: 00 rising, 01 falling, 1x either |
| arm | input | 1 | Host start command, sampled per cycle |
| reinit | input | 1 | Return to idle and clear the triggered flag |
| ana_trig | input | 1 | Asynchronous analog comparator result |
| dig_trig | input | 1 | Asynchronous digital trigger pin |
| start_pulse | output | 1 | Single-cycle conversion start |
| armed | output | 1 | Waiting for a qualifying edge |
| triggered | output | 1 | Start has fired; latched until reinit |

## Verification
The bound checks hold on every cycle for the following properties: the start pulse is one cycle long, it occurs only together with the triggered flag, armed and triggered are never set at once, a pulse arises only from an arm or from the armed state, the triggered state holds against all activity except reinit, and reinit clears the unit. Other behaviour can be shown only by the bench's scenarios, which compare against an independent cycle model. This covers the exact two-cycle synchroniser latency, the three edge senses on both sources, the discard of edges that come before or with the arm, and a level that is already high at arm time.

// File: rtl/trig_arm.sv
module trig_arm #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic [1:0] edge_sel,
  input  logic       arm,
  input  logic       reinit,
  input  logic       ana_trig,
  input  logic       dig_trig,
  output logic       start_pulse,
  output logic       armed,
  output logic       triggered
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_DONE = 2'd2} st_t;

  logic [LAST:0] ana_sync, dig_sync;
  logic          lvl, lvl_q;
  logic          rise, fall, hit;
  logic          soft_src;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ana_sync <= '0;
      dig_sync <= '0;
    end else begin
      ana_sync <= {ana_sync[LAST-1:0], ana_trig};
      dig_sync <= {dig_sync[LAST-1:0], dig_trig};
    end
  end

  assign lvl      = src_sel[1] ? dig_sync[LAST] : ana_sync[LAST];
  assign soft_src = (src_sel == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
  assign hit  = edge_sel[1] ? (rise | fall) : (edge_sel[0] ? fall : rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (reinit) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (arm) begin
            if (soft_src) begin
              st          <= ST_DONE;
              start_pulse <= 1'b1;
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_WAIT: if (hit) begin
            st          <= ST_DONE;
            start_pulse <= 1'b1;
          end
          ST_DONE: st <= ST_DONE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign armed     = (st == ST_WAIT);
  assign triggered = (st == ST_DONE);

endmodule

// File: rtl/trig_arm_chk.sv
module trig_arm_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic reinit,
  input logic start_pulse,
  input logic armed,
  input logic triggered
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R7

  AST_PULSE_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> triggered && !armed); // R7

  AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && triggered)); // R7

  AST_REINIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !armed && !triggered && !start_pulse); // R9

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !reinit) |=> triggered && !start_pulse); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !triggered && !arm) |=> !start_pulse && !triggered); // R6

  AST_WAIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reinit) |=> armed || (triggered && start_pulse)); // R10

endmodule

bind trig_arm trig_arm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .reinit(reinit),
  .start_pulse(start_pulse), .armed(armed), .triggered(triggered)
);

// File: tb/tb_trig_arm.sv
module tb_trig_arm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00, edge_sel = 2'b00;
  logic arm = 1'b0, reinit = 1'b0, ana_trig = 1'b0, dig_trig = 1'b0;
  logic start_pulse, armed, triggered;

  int total = 0, bad = 0, pulses = 0;
  bit done = 1'b0;

  // model state
  logic a1 = 0, a2 = 0, d1 = 0, d2 = 0, prv = 0, m_pulse = 0;
  int   m_st = 0; // 0 idle, 1 waiting, 2 fired

  always #2.5 clk = ~clk;

  trig_arm dut (.*);

  function automatic bit qual(input logic p, input logic n, input logic [1:0] e);
    if (e[1]) return p != n;
    if (e[0]) return p & ~n;
    return ~p & n;
  endfunction

  task automatic model_step();
    logic lv;
    lv = src_sel[1] ? d2 : a2;
    m_pulse = 0;
    if (reinit) m_st = 0;
    else if (m_st == 0 && arm) begin
      if (src_sel == 2'b00) begin m_st = 2; m_pulse = 1; end
      else m_st = 1;
    end else if (m_st == 1 && qual(prv, lv, edge_sel)) begin
      m_st = 2; m_pulse = 1;
    end
    prv = lv;
    a2 = a1; a1 = ana_trig;
    d2 = d1; d1 = dig_trig;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, start_pulse, m_pulse, "start_pulse");
    chk(tag, armed, m_st == 1, "armed");
    chk(tag, triggered, m_st == 2, "triggered");
    if (start_pulse) pulses++;
  endtask

  task automatic cyc(input logic a, input logic r, input logic at, input logic dt, input string tag);
    arm = a; reinit = r; ana_trig = at; dig_trig = dt;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_n(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, ana_trig, dig_trig, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R1", start_pulse, 0, "start_pulse in reset");
    chk("R1", armed, 0, "armed in reset");
    chk("R1", triggered, 0, "triggered in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    chk("R1", triggered, 0, "triggered after release");

    // R2 software start
    src_sel = 2'b00;
    cyc(1, 0, 0, 0, "R2");
    chk("R2", start_pulse, 1, "soft pulse");
    chk("R2", triggered, 1, "soft triggered");
    cyc(0, 0, 0, 0, "R7");
    chk("R7", start_pulse, 0, "pulse one cycle");
    chk("R7", triggered, 1, "triggered holds");
    // R8 activity ignored after fire
    cyc(1, 0, 1, 1, "R8"); idle_n(4, "R8");
    cyc(0, 0, 0, 0, "R8"); idle_n(4, "R8");
    chk("R8", triggered, 1, "still triggered");
    // R9 reinit has priority over arm
    cyc(1, 1, 0, 0, "R9");
    chk("R9", triggered, 0, "reinit clears");
    chk("R9", armed, 0, "arm ignored with reinit");

    // R3/R4/R5 analog rising, exact latency
    src_sel = 2'b01; edge_sel = 2'b00;
    cyc(1, 0, 0, 0, "R3");
    chk("R3", armed, 1, "armed on external");
    idle_n(3, "R3");
    chk("R3", start_pulse, 0, "no pulse without edge");
    cyc(1, 0, 1, 0, "R10");    // change set up before edge k, arm again
    chk("R10", armed, 1, "rearm no effect");
    cyc(0, 0, 1, 0, "R4");     // after k+1
    chk("R4", start_pulse, 0, "not yet k+1");
    cyc(0, 0, 1, 0, "R4");     // after k+2
    chk("R4", start_pulse, 1, "pulse at k+2");
    idle_n(3, "R7");
    cyc(0, 1, 1, 0, "R9");

    // R6 level already high at arm: rising must not fire
    idle_n(4, "R6");
    cyc(1, 0, 1, 0, "R6");
    p0 = pulses;
    idle_n(5, "R6");
    chk("R6", pulses != p0, 0, "present level fired");
    chk("R6", armed, 1, "still armed");
    // falling then, edge sense 01
    edge_sel = 2'b01;
    cyc(0, 0, 0, 0, "R5"); idle_n(3, "R5");
    chk("R5", triggered, 1, "falling fired");
    cyc(0, 1, 0, 0, "R9");

    // R6 edge before arm discarded; digital either-edge
    src_sel = 2'b10; edge_sel = 2'b10;
    cyc(0, 0, 0, 1, "R6"); idle_n(1, "R6");
    cyc(1, 0, 0, 1, "R6");     // synced rise lands in arm cycle
    idle_n(4, "R6");
    chk("R6", armed, 1, "pre-arm edge discarded");
    cyc(0, 0, 0, 0, "R5"); idle_n(3, "R5");
    chk("R5", triggered, 1, "either edge fired on fall");
    cyc(0, 1, 0, 0, "R9");

    // random
    for (int i = 0; i < 20000; i++) begin
      logic ra, rr, ta, td;
      if ($urandom_range(0, 63) == 0) src_sel = 2'($urandom);
      if ($urandom_range(0, 63) == 0) edge_sel = 2'($urandom);
      ra = ($urandom_range(0, 15) == 0);
      rr = ($urandom_range(0, 40) == 0);
      ta = ($urandom_range(0, 5) == 0) ? ~ana_trig : ana_trig;
      td = ($urandom_range(0, 5) == 0) ? ~dig_trig : dig_trig;
      cyc(ra, rr, ta, td, "R5_R8_rand");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule